// File: doc/BRIEF.md
# Interrupt Mapping and Clear Controller

This block sits in a host bridge between raw level-sensitive interrupt lines and the interrupt-vector outputs seen by the processor side. It takes 32 PCI lines, grouped four per slot, and 16 on-board device lines, which gives 48 vector outputs. Each group of four PCI lines shares one map register. Each on-board line has a map register of its own. A line reaches its vector only while bit 31 of its map register is set. Bits 10:0 of every map register hold a fixed group/number code that software can read but cannot change.

Software reaches the block through a simple register port with a 16-bit offset and 32-bit data. A request is accepted in any cycle in which it is valid. Only the upper word of each 64-bit map slot (address bit 2 set) is live. A block of write-only locations clears a vector that is already asserted. The cleared vector then stays low until its line drops and rises again. A bank of twelve 32-bit words holds bridge control settings.

Top module: `intMapCtl`

## Requirements
- R1: After reset, PCI map register i (0–7) reads 0x7C0 | (i << 2) and on-board map register j (0–15) reads 0x7E0 + j. Bit 31 (enable) is clear in both.
- R2: A map write with address bit 2 set stores data bits 31:11 and leaves bits 10:0 unchanged.
- R3: A map access with address bit 2 clear has no effect: a write is ignored and a read returns zero.
- R4: PCI map registers occupy offsets 0x0C00–0x0C3F, with index (offset & 0x3f) >> 3. On-board map registers occupy 0x1000–0x1080, with index (offset & 0xff) >> 3.
- R5: Vector n (0–31) can be high only while bit 31 of PCI map n >> 2 is set. Vector n (32–47) can be high only while bit 31 of on-board map n − 32 is set. A vector is low in the cycle after its enable is seen clear.
- R6: A vector goes high one cycle after its line is first sampled high while enabled. It goes low one cycle after the line is sampled low. A line that is already high when it becomes enabled does not raise the vector until it falls and rises again.
- R7: A write with address bit 2 set to 0x1400–0x143F clears vector (offset & 0x3f) >> 3. The vector stays low until its line falls and rises again.
- R8: A write with address bit 2 set to 0x1800–0x1860 clears vector 0x20 | ((offset & 0xff) >> 3). The same write with bit 2 clear has no effect.
- R9: Twelve 32-bit control words at 0x2000–0x202F, with index (offset & 0x3f) >> 2, are fully read/write and reset to zero.
- R10: reqReady is always high. A read returns rspValid with data in the cycle after acceptance. Unmapped offsets and the clear locations read as zero.
- R11: Reset disables every vector, drives all vectors low, and restores every map register to its R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Register request valid |
| reqReady | output | 1 | Request accepted (always high) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Register byte offset |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Read data valid, one cycle after the read |
| rspRdata | output | 32 | Read data (zero when no read completes) |
| irqIn | input | 48 | Interrupt lines: 0–31 PCI, 32–47 on-board |
| vecOut | output | 48 | Interrupt vector outputs |

## Verification
The assertions assume that interrupt lines are synchronous to the clock and that reset is held across at least one rising edge, so that the one- and two-cycle histories they use start from reset values. The edge check also assumes that no vector can rise in the first two cycles after reset, which holds because every enable starts clear and takes a write to set. The stimulus changes lines and requests only on falling edges, issues at most one request per cycle, and holds reset for several cycles both at the start and in the middle of the run.

// File: rtl/imcPkg.sv
package imcPkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 16;
  localparam int EN_BIT  = 31;
  localparam int PROT_W  = 11;
  localparam int IDX_W   = 4;
  localparam int VEC_W   = 6;

  localparam logic [ADDR_W-1:0] PCI_MAP_LO  = 16'h0C00;
  localparam logic [ADDR_W-1:0] PCI_MAP_HI  = 16'h0C3F;
  localparam logic [ADDR_W-1:0] OBIO_MAP_LO = 16'h1000;
  localparam logic [ADDR_W-1:0] OBIO_MAP_HI = 16'h1080;
  localparam logic [ADDR_W-1:0] PCI_CLR_LO  = 16'h1400;
  localparam logic [ADDR_W-1:0] PCI_CLR_HI  = 16'h143F;
  localparam logic [ADDR_W-1:0] OBIO_CLR_LO = 16'h1800;
  localparam logic [ADDR_W-1:0] OBIO_CLR_HI = 16'h1860;
  localparam logic [ADDR_W-1:0] CTL_LO      = 16'h2000;
  localparam logic [ADDR_W-1:0] CTL_HI      = 16'h202F;
  localparam logic [VEC_W-1:0]  OBIO_VEC_BASE = 6'h20;

  typedef enum logic [1:0] {RD_ZERO, RD_PCI, RD_OBIO, RD_CTL} rdSrc_e;

  typedef struct packed {
    logic              pciMapWr;
    logic              obioMapWr;
    logic              ctlWr;
    logic              clrEn;
    logic              rdEn;
    rdSrc_e            rdSrc;
    logic [IDX_W-1:0]  mapIdx;
    logic [IDX_W-1:0]  ctlIdx;
    logic [VEC_W-1:0]  clrVec;
    logic [DATA_W-1:0] wdata;
  } imcStrobe_t;

  function automatic logic [DATA_W-1:0] pciMapInit(input int i);
    return DATA_W'(32'h0000_07C0 | (i << 2));
  endfunction

  function automatic logic [DATA_W-1:0] obioMapInit(input int i);
    return DATA_W'(32'h0000_07E0 + i);
  endfunction
endpackage

// File: rtl/imcCtrl.sv
module imcCtrl
  import imcPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output imcStrobe_t        strb
);
  logic accept, hiWord;
  logic inPciMap, inObioMap, inPciClr, inObioClr, inCtl;

  assign reqReady = 1'b1;
  assign accept   = reqValid && reqReady;
  assign hiWord   = reqAddr[2];

  always_comb begin
    inPciMap  = (reqAddr >= PCI_MAP_LO)  && (reqAddr <= PCI_MAP_HI);
    inObioMap = (reqAddr >= OBIO_MAP_LO) && (reqAddr <= OBIO_MAP_HI);
    inPciClr  = (reqAddr >= PCI_CLR_LO)  && (reqAddr <= PCI_CLR_HI);
    inObioClr = (reqAddr >= OBIO_CLR_LO) && (reqAddr <= OBIO_CLR_HI);
    inCtl     = (reqAddr >= CTL_LO)      && (reqAddr <= CTL_HI);
  end

  always_comb begin
    strb           = '0;
    strb.wdata     = reqWdata;
    strb.mapIdx    = inPciMap ? {1'b0, reqAddr[5:3]} : reqAddr[6:3];
    strb.ctlIdx    = reqAddr[5:2];
    strb.clrVec    = inPciClr ? {3'b000, reqAddr[5:3]}
                              : (OBIO_VEC_BASE | {1'b0, reqAddr[7:3]});
    strb.pciMapWr  = accept && reqWrite && inPciMap && hiWord;
    strb.obioMapWr = accept && reqWrite && inObioMap && hiWord;
    strb.ctlWr     = accept && reqWrite && inCtl;
    strb.clrEn     = accept && reqWrite && hiWord && (inPciClr || inObioClr);
    strb.rdEn      = accept && !reqWrite;
    if (inPciMap && hiWord)       strb.rdSrc = RD_PCI;
    else if (inObioMap && hiWord) strb.rdSrc = RD_OBIO;
    else if (inCtl)               strb.rdSrc = RD_CTL;
    else                          strb.rdSrc = RD_ZERO;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= strb.rdEn;
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.pciMapWr, strb.obioMapWr, strb.ctlWr, strb.clrEn, strb.rdEn})); // R4
endmodule

// File: rtl/imcData.sv
module imcData
  import imcPkg::*;
#(
  parameter int NUM_PCI_MAPS  = 8,
  parameter int LINES_PER_MAP = 4,
  parameter int NUM_OBIO      = 16,
  parameter int NUM_CTL       = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  imcStrobe_t             strb,
  input  logic [NUM_PCI_MAPS*LINES_PER_MAP+NUM_OBIO-1:0] irqIn,
  output logic [NUM_PCI_MAPS*LINES_PER_MAP+NUM_OBIO-1:0] vecOut,
  output logic [DATA_W-1:0]      rdData
);
  localparam int NUM_PCI_LINES = NUM_PCI_MAPS * LINES_PER_MAP;
  localparam int NUM_VEC       = NUM_PCI_LINES + NUM_OBIO;
  localparam int PCI_IDX_W     = $clog2(NUM_PCI_MAPS);
  localparam int OBIO_IDX_W    = $clog2(NUM_OBIO);
  localparam int NUM_MAPS      = NUM_PCI_MAPS + NUM_OBIO;

  logic [DATA_W-1:0] pciMap  [NUM_PCI_MAPS];
  logic [DATA_W-1:0] obioMap [NUM_OBIO];
  logic [DATA_W-1:0] ctlReg  [NUM_CTL];
  logic [NUM_VEC-1:0] enVec, prevIn, pend;
  logic [NUM_MAPS*PROT_W-1:0] protBits;

  // map registers: bits 10:0 only ever take the init code
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PCI_MAPS; i++) pciMap[i] <= pciMapInit(i);
      for (int j = 0; j < NUM_OBIO; j++)     obioMap[j] <= obioMapInit(j);
    end else begin
      if (strb.pciMapWr)
        pciMap[strb.mapIdx[PCI_IDX_W-1:0]] <=
          {strb.wdata[DATA_W-1:PROT_W], pciMap[strb.mapIdx[PCI_IDX_W-1:0]][PROT_W-1:0]};
      if (strb.obioMapWr)
        obioMap[strb.mapIdx[OBIO_IDX_W-1:0]] <=
          {strb.wdata[DATA_W-1:PROT_W], obioMap[strb.mapIdx[OBIO_IDX_W-1:0]][PROT_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_CTL; k++) ctlReg[k] <= '0;
    end else if (strb.ctlWr) begin
      ctlReg[strb.ctlIdx] <= strb.wdata;
    end
  end

  // enable fan-out: one map bit per four PCI lines, one per on-board line
  for (genvar n = 0; n < NUM_VEC; n++) begin : g_en
    if (n < NUM_PCI_LINES) begin : g_pci
      assign enVec[n] = pciMap[n / LINES_PER_MAP][EN_BIT];
    end else begin : g_obio
      assign enVec[n] = obioMap[n - NUM_PCI_LINES][EN_BIT];
    end
  end

  // per-vector pending latch: set on an enabled rising edge, dropped on
  // line low, disable or a clear strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIn <= '0;
      pend   <= '0;
    end else begin
      prevIn <= irqIn;
      for (int n = 0; n < NUM_VEC; n++) begin
        if (!enVec[n] || !irqIn[n])                     pend[n] <= 1'b0;
        else if (strb.clrEn && strb.clrVec == VEC_W'(n)) pend[n] <= 1'b0;
        else if (!prevIn[n])                            pend[n] <= 1'b1;
      end
    end
  end

  assign vecOut = pend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.rdEn) begin
      unique case (strb.rdSrc)
        RD_PCI:  rdData <= pciMap[strb.mapIdx[PCI_IDX_W-1:0]];
        RD_OBIO: rdData <= obioMap[strb.mapIdx[OBIO_IDX_W-1:0]];
        RD_CTL:  rdData <= ctlReg[strb.ctlIdx];
        default: rdData <= '0;
      endcase
    end else begin
      rdData <= '0;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_PCI_MAPS; i++)
      protBits[i*PROT_W +: PROT_W] = pciMap[i][PROT_W-1:0];
    for (int j = 0; j < NUM_OBIO; j++)
      protBits[(NUM_PCI_MAPS+j)*PROT_W +: PROT_W] = obioMap[j][PROT_W-1:0];
  end

  AST_PROT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    $stable(protBits)); // R2
  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (vecOut & ~$past(enVec)) == '0); // R5
  AST_RISE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    ((vecOut & ~$past(vecOut)) & ~($past(irqIn) & ~$past(irqIn, 2))) == '0); // R6
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrEn |=> (vecOut[$past(strb.clrVec)] == 1'b0)); // R7
  AST_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.rdSrc == RD_ZERO) |=> (rdData == '0)); // R10
endmodule

// File: rtl/intMapCtl.sv
module intMapCtl
  import imcPkg::*;
#(
  parameter int NUM_PCI_MAPS  = 8,
  parameter int LINES_PER_MAP = 4,
  parameter int NUM_OBIO      = 16,
  parameter int NUM_CTL       = 12,
  localparam int NUM_VEC      = NUM_PCI_MAPS * LINES_PER_MAP + NUM_OBIO
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic               reqWrite,
  input  logic [15:0]        reqAddr,
  input  logic [31:0]        reqWdata,
  output logic               rspValid,
  output logic [31:0]        rspRdata,
  input  logic [NUM_VEC-1:0] irqIn,
  output logic [NUM_VEC-1:0] vecOut
);
  imcStrobe_t strb;

  imcCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .rspValid (rspValid),
    .strb     (strb)
  );

  imcData #(
    .NUM_PCI_MAPS  (NUM_PCI_MAPS),
    .LINES_PER_MAP (LINES_PER_MAP),
    .NUM_OBIO      (NUM_OBIO),
    .NUM_CTL       (NUM_CTL)
  ) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .irqIn  (irqIn),
    .vecOut (vecOut),
    .rdData (rspRdata)
  );
endmodule

// File: tb/tb_intMapCtl.sv
`timescale 1ns/1ps
module tb_intMapCtl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [47:0] irqIn = '0;
  logic        reqReady, rspValid;
  logic [31:0] rspRdata;
  logic [47:0] vecOut;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  intMapCtl dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .irqIn(irqIn), .vecOut(vecOut)
  );

  // behavioural reference model
  logic [31:0] mPci [8];
  logic [31:0] mObio[16];
  logic [31:0] mCtl [12];
  logic [47:0] mPend, mPrev;
  logic        mRspValid;
  logic [31:0] mRspData;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++)  mPci[i]  = 32'h7C0 | (i << 2);
      for (int j = 0; j < 16; j++) mObio[j] = 32'h7E0 + j;
      for (int k = 0; k < 12; k++) mCtl[k]  = 0;
      mPend = 0; mPrev = 0; mRspValid = 0; mRspData = 0;
    end else begin
      int a;
      bit wr, hi, clr;
      int cv;
      logic [47:0] nPend;
      a = reqAddr; wr = reqValid && reqWrite; hi = reqAddr[2];
      clr = 0; cv = -1;
      if (wr && hi && a >= 'h1400 && a <= 'h143F) begin clr = 1; cv = (a & 'h3f) >> 3; end
      if (wr && hi && a >= 'h1800 && a <= 'h1860) begin clr = 1; cv = 'h20 | ((a & 'hff) >> 3); end
      nPend = mPend;
      for (int n = 0; n < 48; n++) begin
        bit en;
        en = (n < 32) ? mPci[n / 4][31] : mObio[n - 32][31];
        if (!en || !irqIn[n]) nPend[n] = 0;
        else if (clr && cv == n) nPend[n] = 0;
        else if (!mPrev[n]) nPend[n] = 1;
      end
      mRspValid = reqValid && !reqWrite;
      mRspData = 0;
      if (reqValid && !reqWrite) begin
        if (hi && a >= 'h0C00 && a <= 'h0C3F)      mRspData = mPci[(a & 'h3f) >> 3];
        else if (hi && a >= 'h1000 && a <= 'h1080) mRspData = mObio[(a & 'hff) >> 3];
        else if (a >= 'h2000 && a <= 'h202F)       mRspData = mCtl[(a & 'h3f) >> 2];
      end
      if (wr && hi && a >= 'h0C00 && a <= 'h0C3F)
        mPci[(a & 'h3f) >> 3] = (reqWdata & 32'hFFFF_F800) | (mPci[(a & 'h3f) >> 3] & 32'h7FF);
      if (wr && hi && a >= 'h1000 && a <= 'h1080)
        mObio[(a & 'hff) >> 3] = (reqWdata & 32'hFFFF_F800) | (mObio[(a & 'hff) >> 3] & 32'h7FF);
      if (wr && a >= 'h2000 && a <= 'h202F) mCtl[(a & 'h3f) >> 2] = reqWdata;
      mPend = nPend;
      mPrev = irqIn;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R5 R6 vector vs model", {16'h0, vecOut}, {16'h0, mPend});
      chk("R10 response vs model", {31'h0, rspValid, rspRdata}, {31'h0, mRspValid, mRspData});
      chk("R10 ready", {63'h0, reqReady}, 64'h1);
    end
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 0; reqWrite = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqAddr = a;
    @(negedge clk);
    reqValid = 0;
    chk("R10 rspValid after read", {63'h0, rspValid}, 64'h1);
    d = rspRdata;
  endtask

  task automatic rdChk(input string req, input logic [15:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, {32'h0, d}, {32'h0, exp});
  endtask

  task automatic setIrq(input int n, input bit v);
    @(negedge clk);
    irqIn[n] = v;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    doReset();
    chk("R11 vectors low after reset", {16'h0, vecOut}, 64'h0);
    chk("R10 no response after reset", {63'h0, rspValid}, 64'h0);

    for (int i = 0; i < 8; i++)
      rdChk("R1 R4 pci map init", 16'h0C04 + 16'(i * 8), 32'h7C0 | 32'(i << 2));
    for (int j = 0; j < 16; j++)
      rdChk("R1 R4 obio map init", 16'h1004 + 16'(j * 8), 32'h7E0 + 32'(j));
    rdChk("R3 low word read zero pci", 16'h0C00, 32'h0);
    rdChk("R3 low word read zero obio", 16'h1008, 32'h0);

    wr(16'h0C14, 32'hFFFF_FFFF);
    rdChk("R2 protected field kept", 16'h0C14, 32'hFFFF_FFC8);
    wr(16'h0C10, 32'h0);
    rdChk("R3 low word write ignored", 16'h0C14, 32'hFFFF_FFC8);
    wr(16'h1014, 32'h1234_5678);
    rdChk("R2 R4 obio write", 16'h1014, 32'h1234_57E2);

    // gating on group 2 (lines 8..11), group 0 still disabled
    setIrq(9, 1);
    @(negedge clk);
    chk("R5 R6 enabled line raises vector", {63'h0, vecOut[9]}, 64'h1);
    setIrq(1, 1);
    @(negedge clk);
    chk("R5 disabled line stays low", {63'h0, vecOut[1]}, 64'h0);
    setIrq(9, 0);
    @(negedge clk);
    chk("R6 vector follows line low", {63'h0, vecOut[9]}, 64'h0);

    wr(16'h0C04, 32'h8000_0000);
    @(negedge clk);
    chk("R6 already-high line needs new edge", {63'h0, vecOut[1]}, 64'h0);
    setIrq(2, 1);
    @(negedge clk);
    chk("R6 vector 2 up", {63'h0, vecOut[2]}, 64'h1);
    wr(16'h1414, 32'h0);
    chk("R7 pci clear drops vector", {63'h0, vecOut[2]}, 64'h0);
    repeat (2) @(negedge clk);
    chk("R7 cleared vector stays low", {63'h0, vecOut[2]}, 64'h0);
    setIrq(2, 0);
    setIrq(2, 1);
    @(negedge clk);
    chk("R7 re-edge raises vector", {63'h0, vecOut[2]}, 64'h1);
    wr(16'h0C04, 32'h0);
    @(negedge clk);
    chk("R5 disable forces low", {63'h0, vecOut[2]}, 64'h0);

    wr(16'h101C, 32'h8000_0000);
    setIrq(35, 1);
    @(negedge clk);
    chk("R5 obio line raises vector", {63'h0, vecOut[35]}, 64'h1);
    wr(16'h181C, 32'h0);
    chk("R8 obio clear drops vector", {63'h0, vecOut[35]}, 64'h0);
    setIrq(35, 0);
    setIrq(35, 1);
    @(negedge clk);
    wr(16'h1818, 32'h0);
    @(negedge clk);
    chk("R8 low word clear ignored", {63'h0, vecOut[35]}, 64'h1);

    rdChk("R9 control reset zero", 16'h2000, 32'h0);
    wr(16'h2000, 32'hDEAD_BEEF);
    wr(16'h202C, 32'h0BAD_F00D);
    rdChk("R9 control word 0", 16'h2000, 32'hDEAD_BEEF);
    rdChk("R9 control word 11", 16'h202C, 32'h0BAD_F00D);
    rdChk("R9 control word 1 untouched", 16'h2004, 32'h0);
    rdChk("R10 unmapped reads zero", 16'h3000, 32'h0);
    rdChk("R10 clear location reads zero", 16'h1414, 32'h0);

    doReset();
    chk("R11 vectors low after mid reset", {16'h0, vecOut}, 64'h0);
    rdChk("R11 pci map restored", 16'h0C14, 32'h7C8);
    rdChk("R11 obio map restored", 16'h101C, 32'h7E3);
    rdChk("R11 control cleared", 16'h2000, 32'h0);
    @(negedge clk);
    chk("R11 line high yet disabled", {63'h0, vecOut[35]}, 64'h0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule